// File: doc/BRIEF.md
# Flag Threshold Programming Port

This block stores the two thresholds that a FIFO's almost-empty and almost-full flags compare against: the empty threshold (n) and the full threshold (m). Software or a host reaches them through the FIFO's own data pins. Each threshold is split into a low part and a high part, which gives four small registers. One circular selector walks them in a fixed order. Each access with the load pin low touches the register under the selector and then moves the selector on.

The load pin does one of two jobs, picked by its level while reset is held. If it is low during reset, it acts as the programming strobe: a write edge with load low stores the data word into the selected register, and a read edge with load low returns the selected register on the readback port. If it is high during reset, the block runs in two-enable mode. In that mode the pin is only a second write enable, and the thresholds keep their reset values. In both modes the block decodes when an edge is an ordinary FIFO write or read, and reports this on plain request pins for the storage logic.

Readback leaves the block as a one-beat stream. A valid strobe marks the beat, and there is no ready input, so the consumer must take the word in the cycle it appears. The thresholds that the flag logic sees are copied from the registers only while load is high. A partly reprogrammed value therefore never reaches the flags. All logic runs on one clock. For split-clock use, the write and read clocks are tied together.

Top module: `ofs_prog_if`

## Requirements
- R1: In programming mode, successive edges with load_n=0 and wr_en_n=0 store wr_data into selector positions in the order 0 empty-low, 1 empty-high, 2 full-low, 3 full-high, and then wrap back to 0.
- R2: In programming mode, fifo_wr_req is 1 only when load_n=1 and wr_en_n=0. An edge with load_n=0 and wr_en_n=1 changes no register and does not move the selector.
- R3: The selector keeps its position while load_n is high. The next programming access after load_n falls again uses the register after the last one accessed.
- R4: In programming mode, an edge with load_n=0, rd_en1_n=0, rd_en2_n=0 and wr_en_n=1 puts the selected register on rd_data, with rd_valid=1, in the following cycle. It then moves the selector in the same order as writes. Readback has no back-pressure.
- R5: Reset sets both thresholds to 7 and the selector to position 0, and clears rd_valid.
- R6: A low register keeps bits 8:0 of a threshold. A high register keeps only bits OFS_W-1:9, and its readback has all higher bits zero.
- R7: load_n is sampled while rst_n is low. If it was high, the block is in two-enable mode (prog_mode=0): no register access occurs, rd_valid stays 0, fifo_wr_req = !wr_en_n & load_n, and fifo_rd_req = !rd_en1_n & !rd_en2_n.
- R8: If a programming write and a programming read occur on the same edge, only the write happens, rd_valid stays 0, and the selector advances once.
- R9: empty_ofs and full_ofs are updated from the registers only on edges where load_n=1. They hold their value across edges where load_n=0.
- R10: In programming mode, fifo_rd_req is 1 only when load_n=1 and both read enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Synchronous active-low reset; load_n is sampled while low |
| load_n | input | 1 | Programming strobe (active low) or second write enable, chosen at reset |
| wr_en_n | input | 1 | Write enable, active low |
| rd_en1_n | input | 1 | Read enable one, active low |
| rd_en2_n | input | 1 | Read enable two, active low |
| wr_data | input | 9 | Data word from the FIFO input pins |
| rd_data | output | 9 | Readback word of the selected register |
| rd_valid | output | 1 | rd_data carries a new readback beat this cycle |
| empty_ofs | output | OFS_W | Published empty threshold n |
| full_ofs | output | OFS_W | Published full threshold m |
| fifo_wr_req | output | 1 | This edge is an ordinary FIFO write |
| fifo_rd_req | output | 1 | This edge is an ordinary FIFO read |
| prog_mode | output | 1 | 1 when the programming interface is active |

## Verification
Every cycle, the properties check four things: the mode holds steady after reset, no FIFO write request is raised while programming, readback beats come only from a legal read access on the previous edge, and the published thresholds stay frozen across edges with load low. Only the bench scenarios can show the register order, the wrap, resuming after a partial burst, the truncation of high parts, and that a combined read and write moves the selector once. These need the values written to be compared with the values read back later through the same port.

// File: rtl/ofs_prog_pkg.sv
package ofs_prog_pkg;
  localparam int PORT_W = 9;

  typedef enum logic [1:0] {
    SEL_EMPTY_LO = 2'd0,
    SEL_EMPTY_HI = 2'd1,
    SEL_FULL_LO  = 2'd2,
    SEL_FULL_HI  = 2'd3
  } ofs_sel_e;
endpackage

// File: rtl/ofs_mode_ctl.sv
module ofs_mode_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic load_n,
  input  logic wr_en_n,
  input  logic rd_en1_n,
  input  logic rd_en2_n,
  output logic prog_mode,
  output logic ofs_wr,
  output logic ofs_rd,
  output logic fifo_wr_req,
  output logic fifo_rd_req
);
  logic mode_q;
  logic wr_act;
  logic rd_act;

  // The level of load_n during reset picks the pin's role
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= ~load_n;
  end

  assign prog_mode = mode_q;
  assign wr_act    = ~wr_en_n;
  assign rd_act    = ~rd_en1_n & ~rd_en2_n;

  always_comb begin
    ofs_wr      = 1'b0;
    ofs_rd      = 1'b0;
    fifo_wr_req = 1'b0;
    fifo_rd_req = 1'b0;
    if (rst_n) begin
      if (mode_q) begin
        ofs_wr      = ~load_n & wr_act;
        ofs_rd      = ~load_n & rd_act & ~wr_act;  // write wins a collision
        fifo_wr_req = load_n & wr_act;
        fifo_rd_req = load_n & rd_act;
      end else begin
        fifo_wr_req = load_n & wr_act;
        fifo_rd_req = rd_act;
      end
    end
  end
endmodule

// File: rtl/ofs_regfile.sv
module ofs_regfile #(
  parameter int OFS_W       = 11,
  parameter int DEFAULT_OFS = 7
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              ofs_wr,
  input  logic                              ofs_rd,
  input  logic [ofs_prog_pkg::PORT_W-1:0]   wr_data,
  output logic [ofs_prog_pkg::PORT_W-1:0]   rd_data,
  output logic                              rd_valid,
  output logic [OFS_W-1:0]                  empty_raw,
  output logic [OFS_W-1:0]                  full_raw
);
  import ofs_prog_pkg::*;

  localparam int  LO_W    = (OFS_W < PORT_W) ? OFS_W : PORT_W;
  localparam bit  HAS_HI  = (OFS_W > PORT_W);
  localparam int  HI_W    = HAS_HI ? (OFS_W - PORT_W) : 1;

  ofs_sel_e              sel_q;
  logic [LO_W-1:0]       e_lo_q, f_lo_q;
  logic [PORT_W-1:0]     e_hi_view, f_hi_view;
  logic [PORT_W-1:0]     rd_mux;
  logic [PORT_W-1:0]     rd_data_q;
  logic                  rd_valid_q;

  // Selector: one shared position for writes and reads
  always_ff @(posedge clk) begin
    if (!rst_n)                sel_q <= SEL_EMPTY_LO;
    else if (ofs_wr || ofs_rd) sel_q <= ofs_sel_e'(sel_q + 2'd1);
  end

  // Low parts
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_lo_q <= LO_W'(DEFAULT_OFS);
      f_lo_q <= LO_W'(DEFAULT_OFS);
    end else if (ofs_wr) begin
      if (sel_q == SEL_EMPTY_LO) e_lo_q <= wr_data[LO_W-1:0];
      if (sel_q == SEL_FULL_LO)  f_lo_q <= wr_data[LO_W-1:0];
    end
  end

  // High parts exist only when the depth needs more than one port word
  generate
    if (HAS_HI) begin : g_hi
      logic [HI_W-1:0] e_hi_q, f_hi_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          e_hi_q <= HI_W'(DEFAULT_OFS >> PORT_W);
          f_hi_q <= HI_W'(DEFAULT_OFS >> PORT_W);
        end else if (ofs_wr) begin
          if (sel_q == SEL_EMPTY_HI) e_hi_q <= wr_data[HI_W-1:0];
          if (sel_q == SEL_FULL_HI)  f_hi_q <= wr_data[HI_W-1:0];
        end
      end
      assign e_hi_view = PORT_W'(e_hi_q);
      assign f_hi_view = PORT_W'(f_hi_q);
      assign empty_raw = {e_hi_q, e_lo_q};
      assign full_raw  = {f_hi_q, f_lo_q};
    end else begin : g_no_hi
      assign e_hi_view = '0;
      assign f_hi_view = '0;
      assign empty_raw = OFS_W'(e_lo_q);
      assign full_raw  = OFS_W'(f_lo_q);
    end
  endgenerate

  always_comb begin
    unique case (sel_q)
      SEL_EMPTY_LO: rd_mux = PORT_W'(e_lo_q);
      SEL_EMPTY_HI: rd_mux = e_hi_view;
      SEL_FULL_LO:  rd_mux = PORT_W'(f_lo_q);
      SEL_FULL_HI:  rd_mux = f_hi_view;
      default:      rd_mux = '0;
    endcase
  end

  // Readback beat: registered, held between beats
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= ofs_rd;
      if (ofs_rd) rd_data_q <= rd_mux;
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;
endmodule

// File: rtl/ofs_publish.sv
module ofs_publish #(
  parameter int OFS_W       = 11,
  parameter int DEFAULT_OFS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic [OFS_W-1:0] empty_raw,
  input  logic [OFS_W-1:0] full_raw,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs
);
  // Copy only while no programming burst is open
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      empty_ofs <= OFS_W'(DEFAULT_OFS);
      full_ofs  <= OFS_W'(DEFAULT_OFS);
    end else if (load_n) begin
      empty_ofs <= empty_raw;
      full_ofs  <= full_raw;
    end
  end
endmodule

// File: rtl/ofs_prog_if.sv
module ofs_prog_if #(
  parameter int DEPTH       = 2048,
  parameter int DEFAULT_OFS = 7,
  parameter int OFS_W       = $clog2(DEPTH)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            load_n,
  input  logic                            wr_en_n,
  input  logic                            rd_en1_n,
  input  logic                            rd_en2_n,
  input  logic [ofs_prog_pkg::PORT_W-1:0] wr_data,
  output logic [ofs_prog_pkg::PORT_W-1:0] rd_data,
  output logic                            rd_valid,
  output logic [OFS_W-1:0]                empty_ofs,
  output logic [OFS_W-1:0]                full_ofs,
  output logic                            fifo_wr_req,
  output logic                            fifo_rd_req,
  output logic                            prog_mode
);
  logic             ofs_wr;
  logic             ofs_rd;
  logic [OFS_W-1:0] empty_raw;
  logic [OFS_W-1:0] full_raw;

  ofs_mode_ctl u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_n      (load_n),
    .wr_en_n     (wr_en_n),
    .rd_en1_n    (rd_en1_n),
    .rd_en2_n    (rd_en2_n),
    .prog_mode   (prog_mode),
    .ofs_wr      (ofs_wr),
    .ofs_rd      (ofs_rd),
    .fifo_wr_req (fifo_wr_req),
    .fifo_rd_req (fifo_rd_req)
  );

  ofs_regfile #(.OFS_W(OFS_W), .DEFAULT_OFS(DEFAULT_OFS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ofs_wr    (ofs_wr),
    .ofs_rd    (ofs_rd),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .empty_raw (empty_raw),
    .full_raw  (full_raw)
  );

  ofs_publish #(.OFS_W(OFS_W), .DEFAULT_OFS(DEFAULT_OFS)) u_pub (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_n    (load_n),
    .empty_raw (empty_raw),
    .full_raw  (full_raw),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs)
  );
endmodule

// File: rtl/ofs_prog_if_chk.sv
module ofs_prog_if_chk #(
  parameter int OFS_W       = 11,
  parameter int DEFAULT_OFS = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_n,
  input logic             wr_en_n,
  input logic             rd_en1_n,
  input logic             rd_en2_n,
  input logic             rd_valid,
  input logic [OFS_W-1:0] empty_ofs,
  input logic [OFS_W-1:0] full_ofs,
  input logic             fifo_wr_req,
  input logic             prog_mode
);
  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(prog_mode)); // R7

  AST_RESET_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (empty_ofs == OFS_W'(DEFAULT_OFS)) && (full_ofs == OFS_W'(DEFAULT_OFS))); // R5

  AST_NO_FIFO_WR_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_mode && !load_n) |-> !fifo_wr_req); // R2

  AST_READBACK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(prog_mode && !load_n && !rd_en1_n && !rd_en2_n && wr_en_n)); // R4

  AST_PUBLISH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(load_n)) |-> ($stable(empty_ofs) && $stable(full_ofs))); // R9
endmodule

bind ofs_prog_if ofs_prog_if_chk #(.OFS_W(OFS_W), .DEFAULT_OFS(DEFAULT_OFS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_n      (load_n),
  .wr_en_n     (wr_en_n),
  .rd_en1_n    (rd_en1_n),
  .rd_en2_n    (rd_en2_n),
  .rd_valid    (rd_valid),
  .empty_ofs   (empty_ofs),
  .full_ofs    (full_ofs),
  .fifo_wr_req (fifo_wr_req),
  .prog_mode   (prog_mode)
);

// File: tb/ofs_prog_if_test.sv
module ofs_prog_if_test;
  localparam int OFS_W = 11;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             load_n = 1'b0;
  logic             wr_en_n = 1'b1;
  logic             rd_en1_n = 1'b1;
  logic             rd_en2_n = 1'b1;
  logic [8:0]       wr_data = '0;
  logic [8:0]       rd_data;
  logic             rd_valid;
  logic [OFS_W-1:0] empty_ofs, full_ofs;
  logic             fifo_wr_req, fifo_rd_req, prog_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [8:0] exp_q[$];

  always #2 clk = ~clk;  // 250 MHz

  ofs_prog_if uut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .wr_en_n(wr_en_n),
    .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .wr_data(wr_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .empty_ofs(empty_ofs),
    .full_ofs(full_ofs), .fifo_wr_req(fifo_wr_req),
    .fifo_rd_req(fifo_rd_req), .prog_mode(prog_mode)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Driver: one edge of stimulus; a legal readback pushes its expected word
  task automatic step(input logic l, input logic w, input logic r,
                      input logic [8:0] d, input logic expect_rd,
                      input logic [8:0] exp_word);
    @(negedge clk);
    load_n = l; wr_en_n = w; rd_en1_n = r; rd_en2_n = r; wr_data = d;
    if (expect_rd) exp_q.push_back(exp_word);
  endtask

  task automatic idle();
    step(1'b1, 1'b1, 1'b1, 9'h0, 1'b0, 9'h0);
  endtask

  task automatic do_reset(input logic l);
    @(negedge clk);
    rst_n = 1'b0; load_n = l; wr_en_n = 1'b1; rd_en1_n = 1'b1; rd_en2_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; load_n = 1'b1;
  endtask

  // Monitor: every readback beat must match the oldest expected word
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8/R7: unexpected readback actual 0x%0h expected none", rd_data);
      end else begin
        check("R4 readback word", rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Programming mode, R5 defaults
    do_reset(1'b0);
    @(negedge clk);
    check("R5 empty default", empty_ofs, 7);
    check("R5 full default", full_ofs, 7);
    check("R5 rd_valid clear", rd_valid, 0);
    check("R7 prog_mode set", prog_mode, 1);

    // R4/R5/R6: read all four defaults starting at position 0
    step(1'b0, 1'b1, 1'b0, 9'h0, 1'b1, 9'h007);
    step(1'b0, 1'b1, 1'b0, 9'h0, 1'b1, 9'h000);
    step(1'b0, 1'b1, 1'b0, 9'h0, 1'b1, 9'h007);
    step(1'b0, 1'b1, 1'b0, 9'h0, 1'b1, 9'h000);

    // R1: write all four in order, selector wraps to position 0
    step(1'b0, 1'b0, 1'b1, 9'h1A5, 1'b0, 9'h0);
    step(1'b0, 1'b0, 1'b1, 9'h003, 1'b0, 9'h0);
    step(1'b0, 1'b0, 1'b1, 9'h0FF, 1'b0, 9'h0);
    step(1'b0, 1'b0, 1'b1, 9'h002, 1'b0, 9'h0);
    step(1'b0, 1'b1, 1'b1, 9'h0, 1'b0, 9'h0);
    check("R9 frozen while load low", empty_ofs, 7);
    idle();
    idle();
    check("R1 empty assembled", empty_ofs, 11'h7A5);
    check("R1 full assembled", full_ofs, 11'h4FF);

    // R3: partial burst, then resume
    step(1'b0, 1'b0, 1'b1, 9'h011, 1'b0, 9'h0);  // position 0, selector -> 1
    step(1'b1, 1'b0, 1'b1, 9'h0AA, 1'b0, 9'h0);
    #1 check("R2 normal fifo write", fifo_wr_req, 1);
    step(1'b0, 1'b1, 1'b1, 9'h0AA, 1'b0, 9'h0);
    #1 check("R2 load low no enable", fifo_wr_req, 0);
    step(1'b1, 1'b1, 1'b1, 9'h0AA, 1'b0, 9'h0);
    #1 check("R2 both high no op", fifo_wr_req, 0);
    // R6: high part keeps only two bits
    step(1'b0, 1'b0, 1'b1, 9'h1FF, 1'b0, 9'h0);  // position 1, selector -> 2
    step(1'b0, 1'b1, 1'b0, 9'h0, 1'b1, 9'h0FF);  // R3 position 2
    step(1'b0, 1'b1, 1'b0, 9'h0, 1'b1, 9'h002);
    step(1'b0, 1'b1, 1'b0, 9'h0, 1'b1, 9'h011);
    step(1'b0, 1'b1, 1'b0, 9'h0, 1'b1, 9'h003);  // R6 truncated high part

    // R8: collision at position 2, write wins, selector moves once
    step(1'b0, 1'b0, 1'b0, 9'h055, 1'b0, 9'h0);
    step(1'b0, 1'b1, 1'b0, 9'h0, 1'b1, 9'h002);  // position 3 shows single advance

    // R10: read request decode
    step(1'b1, 1'b1, 1'b0, 9'h0, 1'b0, 9'h0);
    #1 check("R10 fifo read with load high", fifo_rd_req, 1);
    step(1'b0, 1'b1, 1'b0, 9'h0, 1'b1, 9'h011);
    #1 check("R10 no fifo read while loading", fifo_rd_req, 0);
    idle();
    idle();
    check("R9 published empty", empty_ofs, 11'h611);
    check("R8 published full", full_ofs, 11'h455);

    // R7: two-enable mode
    do_reset(1'b1);
    @(negedge clk);
    check("R7 prog_mode clear", prog_mode, 0);
    step(1'b0, 1'b0, 1'b1, 9'h01F, 1'b0, 9'h0);
    #1 check("R7 write needs second enable", fifo_wr_req, 0);
    step(1'b1, 1'b0, 1'b1, 9'h01F, 1'b0, 9'h0);
    #1 check("R7 write with both enables", fifo_wr_req, 1);
    step(1'b0, 1'b1, 1'b0, 9'h0, 1'b0, 9'h0);
    #1 check("R7 read ignores load", fifo_rd_req, 1);
    idle();
    idle();
    check("R7 empty unchanged", empty_ofs, 7);
    check("R7 full unchanged", full_ofs, 7);
    check("R4 all beats seen", exp_q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule